// File: doc/BRIEF.md
# ATA PIO Register Access Engine

This block carries out one programmed-I/O register transfer at a time on a CompactFlash card wired in true-IDE mode. A controller presents a request made of a 5-bit register select, a direction flag and a 16-bit word to be written. The engine then steps the card's chip-select and address lines, its active-low read and write strobes and the output enable of the bidirectional data bus through a fixed timed sequence. On a read it returns the captured 16-bit word together with a one-cycle done pulse.

The register select is laid out as {chip-select 1, chip-select 0, A2, A1, A0}, and both chip-selects are active low. The idle code 0x18 deselects the card. The task-file registers sit at 0x10 to 0x17: data, feature, sector count, the three low address bytes, drive/head, and command/status. Device control and alternate status sit at 0x0E. Every phase length is a clock-count parameter. The defaults suit a 50 MHz clock: 120 ns of address setup, a 240 ns strobe, 40 ns of bus drive after the chip-selects are released, and 240 ns of recovery after each write. Command sequencing and status decoding belong to the logic that issues the requests.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset the address output is 0x18, both strobes are high, the bus output enable is low, and busy, done and the read word are all 0.
- R2: A request accepted while idle places its register select on the address output. The address stays there for exactly 6 clocks before either strobe falls.
- R3: A write lowers only the write strobe and a read lowers only the read strobe. The strobe stays low for exactly 12 clocks, and the two strobes are never low together.
- R4: On a write, the output enable rises with the address and stays high through the strobe. The write word is on the data output for as long as the enable is high.
- R5: On a write, the address is held for 1 clock after the strobe rises and then returns to 0x18. The output enable stays high for a further 2 clocks after that.
- R6: On a write, done asserts after 12 clocks of recovery that follow the fall of the output enable.
- R7: On a read, the output enable stays low for the whole access. The read word equals the data input as sampled in the last clock of the strobe-low period. Changes to the data input after the strobe rises do not alter it.
- R8: On a read, the address is held for 1 clock after the strobe rises. Done asserts in the clock in which the address returns to 0x18.
- R9: Done is a single-clock pulse. Busy is high from the clock after acceptance until done, and busy is low in the clock in which done is high.
- R10: A request raised while busy is ignored. It changes neither the access in progress nor the outputs, and no access follows it.
- R11: An asserted reset in the middle of an access returns every output to the state of R1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 50 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 selects a write, 0 a read |
| req_reg | input | 5 | Register select {cs1_n, cs0_n, A2, A1, A0} |
| req_wdata | input | 16 | Word to be written |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Word captured by the last read |
| ata_addr | output | 5 | Chip-select and address lines to the card |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_doe | output | 1 | Output enable for the data bus drivers |
| ata_dout | output | 16 | Data driven toward the card |
| ata_din | input | 16 | Data returned by the card |

## Verification
The assertions assume that reset is asserted at time zero. They also assume that req_valid may arrive in any state, since the engine is expected to discard requests while busy. The capture check further assumes that the card holds ata_din steady for as long as the read strobe is low. The stimulus drives every input at the falling clock edge. It holds ata_din at the expected word only while the read strobe is low and at the complement of that word otherwise, so a capture made outside the strobe window yields the wrong value. Requests raised while busy are sent with the opposite direction and a different register, so that any effect they had would show at the ports.

// File: rtl/ata_pio_engine.sv
module ata_pio_engine #(
  parameter int SETUP_CLKS   = 6,
  parameter int PULSE_CLKS   = 12,
  parameter int TAIL_CLKS    = 2,
  parameter int RECOVER_CLKS = 12,
  parameter logic [4:0] IDLE_SEL = 5'h18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic [4:0]  ata_addr,
  output logic        ata_rd_n,
  output logic        ata_wr_n,
  output logic        ata_doe,
  output logic [15:0] ata_dout,
  input  logic [15:0] ata_din
);
  localparam int MAXC = (SETUP_CLKS > PULSE_CLKS ? SETUP_CLKS : PULSE_CLKS) >
                        (TAIL_CLKS > RECOVER_CLKS ? TAIL_CLKS : RECOVER_CLKS) ?
                        (SETUP_CLKS > PULSE_CLKS ? SETUP_CLKS : PULSE_CLKS) :
                        (TAIL_CLKS > RECOVER_CLKS ? TAIL_CLKS : RECOVER_CLKS);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_RELEASE, S_TAIL, S_RECOVER} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        wr_q;
  logic [4:0]  sel_q;
  logic [15:0] wdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      wr_q   <= 1'b0;
      sel_q  <= IDLE_SEL;
      wdat_q <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_SETUP;
          cnt    <= '0;
          wr_q   <= req_write;
          sel_q  <= req_reg;
          wdat_q <= req_wdata;
        end
        S_SETUP:
          if (cnt == CW'(SETUP_CLKS - 1)) begin st <= S_STROBE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_STROBE:
          if (cnt == CW'(PULSE_CLKS - 1)) begin
            if (!wr_q) rdata <= ata_din;
            st  <= S_RELEASE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_RELEASE:
          if (wr_q) st <= S_TAIL;
          else begin st <= S_IDLE; done <= 1'b1; end
        S_TAIL:
          if (cnt == CW'(TAIL_CLKS - 1)) begin st <= S_RECOVER; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_RECOVER:
          if (cnt == CW'(RECOVER_CLKS - 1)) begin st <= S_IDLE; cnt <= '0; done <= 1'b1; end
          else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire addr_on = (st == S_SETUP) || (st == S_STROBE) || (st == S_RELEASE);

  assign busy     = (st != S_IDLE);
  assign ata_addr = addr_on ? sel_q : IDLE_SEL;
  assign ata_wr_n = !((st == S_STROBE) && wr_q);
  assign ata_rd_n = !((st == S_STROBE) && !wr_q);
  assign ata_doe  = wr_q && (addr_on || (st == S_TAIL));
  assign ata_dout = wdat_q;

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_rd_n && !ata_wr_n));
  assert_read_bus_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_rd_n |-> !ata_doe);
  assert_strobe_addressed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_rd_n || !ata_wr_n) |-> (ata_addr != IDLE_SEL));
  assert_addr_steady_at_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ata_wr_n) || $fell(ata_rd_n)) |-> $stable(ata_addr));
  assert_drive_past_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ata_wr_n) |-> ata_doe);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(sel_q) && $stable(wr_q));
endmodule

// File: tb/ata_pio_engine_tb_top.sv
module ata_pio_engine_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam logic [4:0] IDLE = 5'h18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_reg = 5'h0;
  logic [15:0] req_wdata = 16'h0, din_val = 16'h0;
  logic busy, done, ata_rd_n, ata_wr_n, ata_doe;
  logic [15:0] rdata, ata_dout, ata_din;
  logic [4:0] ata_addr;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ata_din = ata_rd_n ? ~din_val : din_val;

  ata_pio_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .ata_addr(ata_addr), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
    .ata_doe(ata_doe), .ata_dout(ata_dout), .ata_din(ata_din));

  // {write, reg, wdata, din}
  localparam logic [37:0] VEC [6] = '{
    {1'b1, 5'h11, 16'h0000, 16'h0000},
    {1'b1, 5'h13, 16'hA5C3, 16'h0000},
    {1'b0, 5'h17, 16'h0000, 16'h5058},
    {1'b0, 5'h10, 16'h0000, 16'hBEEF},
    {1'b1, 5'h0E, 16'h0004, 16'h0000},
    {1'b0, 5'h0E, 16'h0000, 16'h8001}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic check_idle(input string req);
    chk({req, " addr"}, ata_addr, IDLE);
    chk({req, " strobes"}, {ata_rd_n, ata_wr_n}, 2'b11);
    chk({req, " doe"}, ata_doe, 0);
    chk({req, " busy/done"}, {busy, done}, 0);
  endtask

  task automatic run_access(input bit wr, input logic [4:0] sel, input logic [15:0] wd,
                            input logic [15:0] din, input bit poke);
    int setup = 0, pulse = 0, post = 0, tail = 0, rec = 0, n = 0;
    int addr_bad = 0, wrong_strobe = 0, doe_miss = 0, doe_bad = 0, busy_bad = 0, extra = 0;
    bit seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_reg = sel; req_wdata = wd; din_val = din;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && n < 200) begin
      if (!ata_rd_n || !ata_wr_n) begin
        pulse++; seen = 1;
        if (wr ? !ata_rd_n : !ata_wr_n) wrong_strobe++;
        if (ata_addr != sel) addr_bad++;
        if (wr && !ata_doe) doe_miss++;
      end else if (!seen) begin
        if (ata_addr == sel) setup++; else addr_bad++;
        if (wr && !ata_doe) doe_miss++;
      end else if (ata_addr != IDLE) begin
        post++;
        if (ata_addr != sel) addr_bad++;
        if (wr && !ata_doe) doe_miss++;
      end else if (ata_doe) tail++;
      else rec++;
      if (ata_doe && (!wr || ata_dout != wd)) doe_bad++;
      if (!busy) busy_bad++;
      if (poke && pulse == 3) begin
        req_valid = 1'b1; req_write = !wr; req_reg = 5'h0E; req_wdata = ~wd;
      end else req_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk("R9 done reached", done, 1);
    chk("R9 busy low with done", busy, 0);
    chk("R2 setup clocks", setup, 6);
    chk("R2 address value", addr_bad, 0);
    chk("R3 strobe low clocks", pulse, 12);
    chk("R3 correct strobe", wrong_strobe, 0);
    chk(wr ? "R5 address hold" : "R8 address hold", post, 1);
    chk("R5 doe tail", tail, wr ? 2 : 0);
    chk("R6 recovery", rec, wr ? 12 : 0);
    chk("R4 doe coverage", doe_miss, 0);
    chk(wr ? "R4 write data" : "R7 read bus off", doe_bad, 0);
    chk("R9 busy through access", busy_bad, 0);
    if (!wr) chk("R8 addr idle at done", ata_addr, IDLE);
    @(negedge clk);
    chk("R9 done single pulse", done, 0);
    if (!wr) chk("R7 read word", rdata, din);
    for (int i = 0; i < 3; i++) begin
      if (busy || ata_addr != IDLE || !ata_rd_n || !ata_wr_n) extra++;
      @(negedge clk);
    end
    chk(poke ? "R10 no access after ignored request" : "R9 quiet after done", extra, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 3);
    check_idle("R1 reset");
    chk("R1 rdata reset", rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");

    for (int i = 0; i < 6; i++) begin
      logic [37:0] v;
      v = VEC[i];
      run_access(v[37], v[36:32], v[31:16], v[15:0], 1'b0);
    end

    // R10: requests while busy, both directions
    run_access(1'b0, 5'h12, 16'h0, 16'h1234, 1'b1);
    run_access(1'b1, 5'h16, 16'h00E5, 16'h0, 1'b1);
    // R7: read word keeps value over a following write
    chk("R7 read word kept after write", rdata, 16'h1234);

    // R11: reset in the middle of a write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_reg = 5'h15; req_wdata = 16'h7777;
    @(negedge clk); req_valid = 1'b0;
    repeat (9) @(negedge clk);
    chk("R11 strobe low before reset", ata_wr_n, 0);
    rst_n = 1'b0;
    #1;
    check_idle("R11 mid-access reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_idle("R11 after reset release");
    run_access(1'b0, 5'h17, 16'h0, 16'h00C0, 1'b0);

    summary();
    $finish;
  end
endmodule